// File: doc/BRIEF.md
# Branch and Skip Condition Unit

This unit decides where a small RISC core fetches next. Decode gives it the class of a flow instruction, the current word address of the program counter and the raw offset field. For the condition tests it also receives the 8-bit status register, a flag index, two register operands, a bit index, the value of one I/O bit, and a flag that says whether the instruction after the current one occupies two words. From these the unit computes the next program counter, whether the flow deviates from plain sequential fetch, and how many cycles the instruction costs.

Relative jumps and calls add a 12-bit signed offset. Conditional branches add a 7-bit signed offset. The condition is either any status flag selected by index, tested for set or for clear, or the signed greater-or-equal / less-than test computed from N and V. Skips compare two registers for equality, test one register bit, or test an I/O bit. When a skip fires, it steps over one or two words. Returns are counted for cycles only: their target comes from the stack logic elsewhere. All three outputs are registered, so each result appears one clock after the inputs that produced it.

Top module: `branch_skip_unit`

## Requirements
- R1: While reset is active and until the first update after release, next_pc is 0, taken is 0 and cycles is 0. After that, the outputs in each cycle reflect the inputs present at the previous rising clock edge.
- R2: Class 1 (relative jump) gives next_pc = pc + k + 1, where k is the 12-bit offset as a signed value. It sets taken = 1 and cycles = 2.
- R3: Class 2 (relative call) gives the same target as R2, with taken = 1 and cycles = 3.
- R4: Class 3 (return) and class 4 (interrupt return) give taken = 1, cycles = 4 and next_pc = pc + 1.
- R5: Class 5 branches when status bit flag_sel is 1, and class 6 branches when it is 0. Bit positions are C=0, Z=1, N=2, V=3, S=4, H=5, T=6, I=7, so carry-clear and same-or-higher are both class 6 with index 0. A taken branch gives next_pc = pc + k + 1, where k is offset[6:0] as a signed value, with taken = 1 and cycles = 2. The upper offset bits have no effect.
- R6: A branch whose condition fails, a skip whose condition fails, class 0, and the unused codes 14 and 15 all give next_pc = pc + 1, taken = 0 and cycles = 1.
- R7: Class 7 (signed greater-or-equal) branches when status bit 2 XOR status bit 3 is 0. Class 8 (signed less-than) branches when it is 1. Status bit 4 has no effect on either.
- R8: Class 9 skips when opa equals opb.
- R9: Class 10 skips when bit bit_sel of opa is 0. Class 11 skips when that bit is 1.
- R10: Class 12 skips when io_bit is 0. Class 13 skips when io_bit is 1.
- R11: A skip that fires sets taken = 1 and cycles = 2. It gives next_pc = pc + 2 when next_two_word is 0, and pc + 3 when next_two_word is 1.
- R12: All program-counter arithmetic wraps modulo 2^9 words, in both directions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fc_class | input | 4 | Flow instruction class code |
| pc | input | 9 | Current program counter (words) |
| offset | input | 12 | Raw signed offset field |
| flag_sel | input | 3 | Status bit index for flag branches |
| sreg | input | 8 | Status register |
| opa | input | 8 | First register operand |
| opb | input | 8 | Second register operand |
| bit_sel | input | 3 | Bit index for register bit skips |
| io_bit | input | 1 | Selected I/O bit value |
| next_two_word | input | 1 | Following instruction is two words long |
| next_pc | output | 9 | Next program counter |
| taken | output | 1 | Flow deviates from sequential |
| cycles | output | 3 | Cycle count of the instruction |

## Verification
The bench builds the unit with its defaults: a 9-bit program counter, a 7-bit branch offset and a 12-bit jump offset. Because the jump offset is wider than the address space, a single jump can wrap around the top or the bottom, which makes R12 reachable from small addresses near 0 and 511. With an 8-entry status register, every flag index can be swept exhaustively for both polarities.

// File: rtl/flow_pkg.sv
package flow_pkg;

  typedef enum logic [3:0] {
    FC_NONE   = 4'd0,
    FC_JUMP   = 4'd1,
    FC_CALL   = 4'd2,
    FC_RET    = 4'd3,
    FC_RETI   = 4'd4,
    FC_BR_SET = 4'd5,
    FC_BR_CLR = 4'd6,
    FC_BR_GE  = 4'd7,
    FC_BR_LT  = 4'd8,
    FC_SK_EQ  = 4'd9,
    FC_SK_RBC = 4'd10,
    FC_SK_RBS = 4'd11,
    FC_SK_IOC = 4'd12,
    FC_SK_IOS = 4'd13
  } flow_cls_e;

  // status bit positions used by the signed tests
  localparam int unsigned NEG_POS = 2;
  localparam int unsigned OVF_POS = 3;

  localparam logic [2:0] CYC_SEQ  = 3'd1;
  localparam logic [2:0] CYC_JUMP = 3'd2;
  localparam logic [2:0] CYC_CALL = 3'd3;
  localparam logic [2:0] CYC_RET  = 3'd4;

endpackage

// File: rtl/flow_rst_sync.sv
module flow_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/flow_tgt_add.sv
module flow_tgt_add #(
  parameter int unsigned PC_W  = 9,
  parameter int unsigned OFF_W = 7
) (
  input  logic [PC_W-1:0]  pc,
  input  logic [OFF_W-1:0] off,
  output logic [PC_W-1:0]  target
);
  logic [PC_W-1:0] off_ext;

  generate
    if (OFF_W >= PC_W) begin : g_trunc
      // wrap arithmetic: only the low PC_W bits matter
      assign off_ext = off[PC_W-1:0];
    end else begin : g_sext
      assign off_ext = {{(PC_W-OFF_W){off[OFF_W-1]}}, off};
    end
  endgenerate

  assign target = pc + off_ext + PC_W'(1);
endmodule

// File: rtl/flow_cond_eval.sv
module flow_cond_eval
  import flow_pkg::*;
#(
  parameter int unsigned SR_W = 8,
  parameter int unsigned OP_W = 8,
  localparam int unsigned FS_W = $clog2(SR_W),
  localparam int unsigned BS_W = $clog2(OP_W)
) (
  input  flow_cls_e         cls,
  input  logic [SR_W-1:0]   sreg,
  input  logic [FS_W-1:0]   flag_sel,
  input  logic [OP_W-1:0]   opa,
  input  logic [OP_W-1:0]   opb,
  input  logic [BS_W-1:0]   bit_sel,
  input  logic              io_bit,
  output logic              br_cond,
  output logic              skip_cond
);
  logic flag_v;
  logic signed_lt;
  logic reg_bit;

  assign flag_v    = sreg[flag_sel];
  assign signed_lt = sreg[NEG_POS] ^ sreg[OVF_POS];
  assign reg_bit   = opa[bit_sel];

  always_comb begin
    br_cond   = 1'b0;
    skip_cond = 1'b0;
    unique case (cls)
      FC_BR_SET: br_cond   = flag_v;
      FC_BR_CLR: br_cond   = ~flag_v;
      FC_BR_GE:  br_cond   = ~signed_lt;
      FC_BR_LT:  br_cond   = signed_lt;
      FC_SK_EQ:  skip_cond = (opa == opb);
      FC_SK_RBC: skip_cond = ~reg_bit;
      FC_SK_RBS: skip_cond = reg_bit;
      FC_SK_IOC: skip_cond = ~io_bit;
      FC_SK_IOS: skip_cond = io_bit;
      default: ;
    endcase
  end
endmodule

// File: rtl/branch_skip_unit.sv
module branch_skip_unit
  import flow_pkg::*;
#(
  parameter int unsigned PC_W   = 9,
  parameter int unsigned BOFF_W = 7,
  parameter int unsigned JOFF_W = 12,
  parameter int unsigned SR_W   = 8,
  parameter int unsigned OP_W   = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned FS_W  = $clog2(SR_W),
  localparam int unsigned BS_W  = $clog2(OP_W)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        fc_class,
  input  logic [PC_W-1:0]   pc,
  input  logic [JOFF_W-1:0] offset,
  input  logic [FS_W-1:0]   flag_sel,
  input  logic [SR_W-1:0]   sreg,
  input  logic [OP_W-1:0]   opa,
  input  logic [OP_W-1:0]   opb,
  input  logic [BS_W-1:0]   bit_sel,
  input  logic              io_bit,
  input  logic              next_two_word,
  output logic [PC_W-1:0]   next_pc,
  output logic              taken,
  output logic [2:0]        cycles
);
  flow_cls_e       cls;
  logic            rst_sync_n;
  logic            br_cond, skip_cond;
  logic [PC_W-1:0] br_tgt, jmp_tgt, seq_pc, skip_pc;
  logic [PC_W-1:0] nxt_pc;
  logic            nxt_taken;
  logic [2:0]      nxt_cyc;

  assign cls = flow_cls_e'(fc_class);

  flow_rst_sync #(.STAGES(SYNC_STAGES)) i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  flow_cond_eval #(.SR_W(SR_W), .OP_W(OP_W)) i_cond (
    .cls(cls), .sreg(sreg), .flag_sel(flag_sel), .opa(opa), .opb(opb),
    .bit_sel(bit_sel), .io_bit(io_bit),
    .br_cond(br_cond), .skip_cond(skip_cond)
  );

  flow_tgt_add #(.PC_W(PC_W), .OFF_W(BOFF_W)) i_br_add (
    .pc(pc), .off(offset[BOFF_W-1:0]), .target(br_tgt)
  );

  flow_tgt_add #(.PC_W(PC_W), .OFF_W(JOFF_W)) i_jmp_add (
    .pc(pc), .off(offset), .target(jmp_tgt)
  );

  assign seq_pc  = pc + PC_W'(1);
  assign skip_pc = pc + (next_two_word ? PC_W'(3) : PC_W'(2));

  // next-state decision
  always_comb begin
    nxt_pc    = seq_pc;
    nxt_taken = 1'b0;
    nxt_cyc   = CYC_SEQ;
    unique case (cls)
      FC_JUMP: begin
        nxt_pc = jmp_tgt; nxt_taken = 1'b1; nxt_cyc = CYC_JUMP;
      end
      FC_CALL: begin
        nxt_pc = jmp_tgt; nxt_taken = 1'b1; nxt_cyc = CYC_CALL;
      end
      FC_RET, FC_RETI: begin
        nxt_taken = 1'b1; nxt_cyc = CYC_RET;
      end
      FC_BR_SET, FC_BR_CLR, FC_BR_GE, FC_BR_LT: begin
        if (br_cond) begin
          nxt_pc = br_tgt; nxt_taken = 1'b1; nxt_cyc = CYC_JUMP;
        end
      end
      FC_SK_EQ, FC_SK_RBC, FC_SK_RBS, FC_SK_IOC, FC_SK_IOS: begin
        if (skip_cond) begin
          nxt_pc = skip_pc; nxt_taken = 1'b1; nxt_cyc = CYC_JUMP;
        end
      end
      default: ;
    endcase
  end

  // output registers
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      next_pc <= '0;
      taken   <= 1'b0;
      cycles  <= '0;
    end else begin
      next_pc <= nxt_pc;
      taken   <= nxt_taken;
      cycles  <= nxt_cyc;
    end
  end
endmodule

// File: rtl/branch_skip_unit_chk.sv
module branch_skip_unit_chk #(
  parameter int unsigned PC_W = 9
) (
  input logic            clk,
  input logic            rst_sync_n,
  input logic [3:0]      fc_class,
  input logic [PC_W-1:0] pc,
  input logic [PC_W-1:0] next_pc,
  input logic            taken,
  input logic [2:0]      cycles
);
  logic armed;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed <= 1'b0;
    else             armed <= 1'b1;
  end

  p_seq_when_not_taken_r6: assert property (@(posedge clk) disable iff (!armed)
    !taken |-> (cycles == 3'd1 && next_pc == PC_W'($past(pc) + 1'b1)));

  p_jump_cost_r2: assert property (@(posedge clk) disable iff (!armed)
    ($past(fc_class) == 4'd1) |-> (taken && cycles == 3'd2));

  p_call_cost_r3: assert property (@(posedge clk) disable iff (!armed)
    ($past(fc_class) == 4'd2) |-> (taken && cycles == 3'd3));

  p_return_cost_r4: assert property (@(posedge clk) disable iff (!armed)
    ($past(fc_class) == 4'd3 || $past(fc_class) == 4'd4)
      |-> (taken && cycles == 3'd4 && next_pc == PC_W'($past(pc) + 1'b1)));

  p_skip_distance_r11: assert property (@(posedge clk) disable iff (!armed)
    (taken && $past(fc_class) >= 4'd9 && $past(fc_class) <= 4'd13)
      |-> (cycles == 3'd2 &&
           (next_pc == PC_W'($past(pc) + 2'd2) || next_pc == PC_W'($past(pc) + 2'd3))));

  p_cycles_range_r1: assert property (@(posedge clk) disable iff (!armed)
    (cycles >= 3'd1 && cycles <= 3'd4));
endmodule

bind branch_skip_unit branch_skip_unit_chk #(.PC_W(PC_W)) i_chk (
  .clk(clk), .rst_sync_n(rst_sync_n), .fc_class(fc_class), .pc(pc),
  .next_pc(next_pc), .taken(taken), .cycles(cycles)
);

// File: tb/test_branch_skip_unit.sv
module test_branch_skip_unit;
  localparam int PC_W = 9, BOFF_W = 7, JOFF_W = 12;
  localparam int PC_MOD = 1 << PC_W;

  logic clk = 1'b0;
  logic rst_n;
  logic [3:0] fc_class;
  logic [PC_W-1:0] pc;
  logic [JOFF_W-1:0] offset;
  logic [2:0] flag_sel, bit_sel;
  logic [7:0] sreg, opa, opb;
  logic io_bit, next_two_word;
  logic [PC_W-1:0] next_pc;
  logic taken;
  logic [2:0] cycles;

  int checks = 0, failures = 0;
  bit have_exp = 0;
  int exp_pc, exp_cyc, exp_tk;
  string exp_tag;

  always #10 clk = ~clk;

  branch_skip_unit #(.PC_W(PC_W), .BOFF_W(BOFF_W), .JOFF_W(JOFF_W)) i_branch_skip_unit (
    .clk(clk), .rst_n(rst_n), .fc_class(fc_class), .pc(pc), .offset(offset),
    .flag_sel(flag_sel), .sreg(sreg), .opa(opa), .opb(opb), .bit_sel(bit_sel),
    .io_bit(io_bit), .next_two_word(next_two_word),
    .next_pc(next_pc), .taken(taken), .cycles(cycles));

  function automatic int wrap(int v);
    return ((v % PC_MOD) + PC_MOD) % PC_MOD;
  endfunction

  task automatic check(string tag, int act, int exp, string what);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic compare();
    if (have_exp) begin
      check(exp_tag, int'(next_pc), exp_pc, "next_pc");
      check(exp_tag, int'(taken), exp_tk, "taken");
      check(exp_tag, int'(cycles), exp_cyc, "cycles");
    end
  endtask

  // behavioural reference: decides from the requirement text
  task automatic step(int cls, int p, int off, int fs, int sr, int a, int b,
                      int bs, int io, int two, string tag);
    int jk, bk, sgn;
    bit hit;
    @(negedge clk);
    compare();
    fc_class = cls[3:0]; pc = p[PC_W-1:0]; offset = off[JOFF_W-1:0];
    flag_sel = fs[2:0]; sreg = sr[7:0]; opa = a[7:0]; opb = b[7:0];
    bit_sel = bs[2:0]; io_bit = io[0]; next_two_word = two[0];
    jk = off % 4096; if (jk >= 2048) jk -= 4096;
    bk = off % 128;  if (bk >= 64)   bk -= 128;
    sgn = ((sr >> 2) & 1) ^ ((sr >> 3) & 1);
    exp_pc = wrap(p + 1); exp_tk = 0; exp_cyc = 1; hit = 0;
    case (cls)
      1: begin exp_pc = wrap(p + jk + 1); exp_tk = 1; exp_cyc = 2; end
      2: begin exp_pc = wrap(p + jk + 1); exp_tk = 1; exp_cyc = 3; end
      3, 4: begin exp_tk = 1; exp_cyc = 4; end
      5, 6, 7, 8: begin
        if (cls == 5) hit = ((sr >> fs) & 1) == 1;
        if (cls == 6) hit = ((sr >> fs) & 1) == 0;
        if (cls == 7) hit = (sgn == 0);
        if (cls == 8) hit = (sgn == 1);
        if (hit) begin exp_pc = wrap(p + bk + 1); exp_tk = 1; exp_cyc = 2; end
      end
      9, 10, 11, 12, 13: begin
        if (cls == 9)  hit = (a % 256) == (b % 256);
        if (cls == 10) hit = ((a >> bs) & 1) == 0;
        if (cls == 11) hit = ((a >> bs) & 1) == 1;
        if (cls == 12) hit = (io & 1) == 0;
        if (cls == 13) hit = (io & 1) == 1;
        if (hit) begin exp_pc = wrap(p + (two ? 3 : 2)); exp_tk = 1; exp_cyc = 2; end
      end
      default: ;
    endcase
    exp_tag = tag; have_exp = 1;
  endtask

  initial begin : watchdog
    #(20 * 100000);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    fc_class = '0; pc = '0; offset = '0; flag_sel = '0; sreg = '0;
    opa = '0; opb = '0; bit_sel = '0; io_bit = 1'b0; next_two_word = 1'b0;
    repeat (3) @(negedge clk);
    check("R1", int'(next_pc), 0, "reset next_pc");
    check("R1", int'(taken), 0, "reset taken");
    check("R1", int'(cycles), 0, "reset cycles");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R6 sequential and unused codes
    step(0, 5, 0, 0, 0, 0, 0, 0, 0, 0, "R6");
    step(14, 9, 100, 0, 255, 0, 0, 0, 0, 0, "R6");
    step(15, 511, 0, 0, 0, 0, 0, 0, 0, 0, "R6_R12");
    // R2 jump, R12 wrap
    step(1, 10, 20, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 10, 12'hFFF, 0, 0, 0, 0, 0, 0, 0, "R2");
    step(1, 100, 12'h800, 0, 0, 0, 0, 0, 0, 0, "R2_R12");
    step(1, 511, 0, 0, 0, 0, 0, 0, 0, 0, "R12");
    // R3 call, R4 returns
    step(2, 200, 300, 0, 0, 0, 0, 0, 0, 0, "R3");
    step(2, 3, 12'hFF0, 0, 0, 0, 0, 0, 0, 0, "R3_R12");
    step(3, 7, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    step(4, 511, 0, 0, 0, 0, 0, 0, 0, 0, "R4");
    // R5 every flag index, both polarities
    for (int i = 0; i < 8; i++) begin
      step(5, 40, 5, i, 1 << i, 0, 0, 0, 0, 0, "R5");
      step(5, 40, 5, i, 255 ^ (1 << i), 0, 0, 0, 0, 0, "R5");
      step(6, 40, 5, i, 1 << i, 0, 0, 0, 0, 0, "R5");
      step(6, 40, 5, i, 255 ^ (1 << i), 0, 0, 0, 0, 0, "R5");
    end
    step(5, 10, 12'hF40, 0, 1, 0, 0, 0, 0, 0, "R5_R12");
    step(6, 30, 12'hA3F, 0, 0, 0, 0, 0, 0, 0, "R5");
    // R7 signed tests, S bit ignored
    step(7, 50, 3, 0, 8'h0C, 0, 0, 0, 0, 0, "R7");
    step(7, 50, 3, 0, 8'h14, 0, 0, 0, 0, 0, "R7");
    step(7, 50, 3, 0, 8'h10, 0, 0, 0, 0, 0, "R7");
    step(8, 50, 3, 0, 8'h04, 0, 0, 0, 0, 0, "R7");
    step(8, 50, 3, 0, 8'h1C, 0, 0, 0, 0, 0, "R7");
    step(8, 50, 3, 0, 8'h10, 0, 0, 0, 0, 0, "R7");
    // R8 compare and skip, R11 length
    step(9, 60, 0, 0, 0, 8'h5A, 8'h5A, 0, 0, 0, "R8_R11");
    step(9, 60, 0, 0, 0, 8'h5A, 8'h5A, 0, 0, 1, "R8_R11");
    step(9, 60, 0, 0, 0, 8'h5A, 8'h5B, 0, 0, 1, "R8");
    step(9, 510, 0, 0, 0, 1, 1, 0, 0, 1, "R11_R12");
    // R9 register bit skips
    for (int b = 0; b < 8; b++) begin
      step(10, 70, 0, 0, 0, 1 << b, 0, b, 0, b & 1, "R9");
      step(11, 70, 0, 0, 0, 1 << b, 0, b, 0, b & 1, "R9");
      step(10, 70, 0, 0, 0, 255 ^ (1 << b), 0, b, 0, 0, "R9");
    end
    // R10 io bit skips
    step(12, 80, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    step(12, 80, 0, 0, 0, 0, 0, 0, 1, 1, "R10");
    step(13, 80, 0, 0, 0, 0, 0, 0, 1, 1, "R10_R11");
    step(13, 80, 0, 0, 0, 0, 0, 0, 0, 0, "R10");
    // mixed stream
    for (int n = 0; n < 400; n++)
      step($urandom % 16, $urandom % 512, $urandom % 4096, $urandom % 8,
           $urandom % 256, $urandom % 4, $urandom % 4, $urandom % 8,
           $urandom % 2, $urandom % 2, "R2_R5_R8_R11");
    @(negedge clk);
    compare();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule